// File: doc/BRIEF.md
# FIFO Interrupt Status Controller

This block holds the interrupt registers of a serial controller that owns a transmit FIFO and a receive FIFO. It watches the two FIFO fill levels and two one-cycle event pulses (receive overflow, transmit underflow). From these it keeps a status register. Software enables and disables interrupt sources through two write-only registers that set and clear a read-only mask. The single level-sensitive interrupt line is raised whenever an enabled status bit is set. Two programmable watermarks decide when the transmit FIFO counts as "running low" and when the receive FIFO counts as "ready".

Software talks to the block through a simple single-cycle register port. Writes take effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The FIFOs are not part of the block; they appear only as level and pulse inputs.

The interrupt line is driven by a two-state machine:
- `IRQ_QUIET` moves to `IRQ_RAISED` (transition *raise*) when any bit of status AND mask is set.
- `IRQ_RAISED` returns to `IRQ_QUIET` (transition *drop*) when no such bit remains.
- Each state otherwise holds (transitions *stay quiet* and *stay raised*).

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the sticky status bits and the whole mask are 0, the transmit watermark reads 1, the receive watermark reads 32 and `irq` is 0. The level status bits reflect the FIFO levels one clock after reset is released.
- R2: The status, enable, disable and mask registers share one layout:
  - bit 0: receive overflow
  - bit 2: transmit below watermark
  - bit 3: transmit full
  - bit 4: receive at or above watermark
  - bit 5: receive full
  - bit 6: transmit underflow

  Bit 1 and bits 7 and up always read 0 and cannot be set.
- R3: One clock after `tx_level` changes, status bit 2 equals (`tx_level` < transmit watermark) and status bit 3 equals (`tx_level` == 63).
- R4: One clock after `rx_level` changes, status bit 4 equals (`rx_level` >= receive watermark) and status bit 5 equals (`rx_level` == 63).
- R5: A pulse on `rx_ovf_pulse` sets status bit 0, and a pulse on `tx_udf_pulse` sets status bit 6, at the next clock edge. Each bit then stays set until cleared.
- R6: A write to address 0x04 clears every sticky status bit whose written bit is 1 and leaves the others unchanged.
  - An event pulse in the same cycle wins over the clear.
  - A level bit whose condition still holds stays set after a clear.
- R7: Writing address 0x08 sets each mask bit whose written bit is 1. Zeros have no effect. The address reads 0.
- R8: Writing address 0x0C clears each mask bit whose written bit is 1. Zeros have no effect. The address reads 0.
- R9: The mask reads at address 0x10. Writes to 0x10 leave it unchanged.
- R10: The transmit watermark at 0x28 and the receive watermark at 0x2C are read/write, 6 bits wide. Their upper bits read 0.
- R11: `irq` goes to 1 one clock after (status AND mask) becomes nonzero. It returns to 0 one clock after (status AND mask) becomes zero.
- R12: Any other address reads 0, and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_level | input | 6 | Transmit FIFO entry count |
| rx_level | input | 6 | Receive FIFO entry count |
| rx_ovf_pulse | input | 1 | One-cycle receive overflow event |
| tx_udf_pulse | input | 1 | One-cycle transmit underflow event |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is an event pulse landing in the same clock as a write-1-to-clear of the same bit. The stimulus reaches it by raising `rx_ovf_pulse` and issuing the status write before the same edge, then confirming the bit stays set.

A second awkward case is a clear of a level bit whose condition still holds. It is reached by writing all ones to status while the transmit FIFO is empty and checking that bit 2 survives.

The one-clock interrupt latency is probed by sampling `irq` both at the edge where the mask changes and one edge later.

// File: rtl/fic_pkg.sv
package fic_pkg;
    localparam int NBITS     = 7;
    localparam int B_RX_OVF  = 0;
    localparam int B_TX_LOW  = 2;
    localparam int B_TX_FULL = 3;
    localparam int B_RX_RDY  = 4;
    localparam int B_RX_FULL = 5;
    localparam int B_TX_UDF  = 6;

    localparam logic [NBITS-1:0] STICKY_BITS = 7'b1000001;
    localparam logic [NBITS-1:0] LEVEL_BITS  = 7'b0111100;
    localparam logic [NBITS-1:0] DEF_BITS    = STICKY_BITS | LEVEL_BITS;

    localparam int OFS_STATUS = 'h04;
    localparam int OFS_ENABLE = 'h08;
    localparam int OFS_DISABL = 'h0C;
    localparam int OFS_MASK   = 'h10;
    localparam int OFS_TXWM   = 'h28;
    localparam int OFS_RXWM   = 'h2C;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/fic_status_reg.sv
module fic_status_reg
    import fic_pkg::*;
#(
    parameter int DEPTH = 63,
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_wm,
    input  logic [LVL_W-1:0] rx_wm,
    input  logic             rx_ovf_ev,
    input  logic             tx_udf_ev,
    input  logic [NBITS-1:0] clr,
    output logic [NBITS-1:0] status
);
    logic [NBITS-1:0] lvl_cond;
    logic [NBITS-1:0] evt;

    always_comb begin
        lvl_cond            = '0;
        lvl_cond[B_TX_LOW]  = tx_level < tx_wm;
        lvl_cond[B_TX_FULL] = tx_level == LVL_W'(DEPTH);
        lvl_cond[B_RX_RDY]  = rx_level >= rx_wm;
        lvl_cond[B_RX_FULL] = rx_level == LVL_W'(DEPTH);
        evt                 = '0;
        evt[B_RX_OVF]       = rx_ovf_ev;
        evt[B_TX_UDF]       = tx_udf_ev;
    end

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        if (STICKY_BITS[b]) begin : g_sticky
            always_ff @(posedge clk) begin
                if (!rst_n) status[b] <= 1'b0;
                else        status[b] <= (status[b] & ~clr[b]) | evt[b];
            end
        end else if (LEVEL_BITS[b]) begin : g_level
            always_ff @(posedge clk) begin
                if (!rst_n) status[b] <= 1'b0;
                else        status[b] <= lvl_cond[b];
            end
        end else begin : g_none
            assign status[b] = 1'b0;
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_ev |=> status[B_RX_OVF]); // R5
    AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_udf_ev |=> status[B_TX_UDF]); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_RX_OVF] && !clr[B_RX_OVF]) |=> status[B_RX_OVF]); // R6
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[B_TX_UDF] && !tx_udf_ev) |=> !status[B_TX_UDF]); // R6
    AST_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LVL_W'(DEPTH)) |=> status[B_TX_FULL]); // R3
    AST_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LVL_W'(DEPTH)) |=> status[B_RX_FULL]); // R4
endmodule

// File: rtl/fic_mask_reg.sv
module fic_mask_reg
    import fic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_bits,
    input  logic [NBITS-1:0] clr_bits,
    output logic [NBITS-1:0] mask
);
    logic [NBITS-1:0] mask_nx;

    always_comb mask_nx = (mask | set_bits) & ~clr_bits & DEF_BITS;

    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= mask_nx;
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0 && clr_bits == '0) |=>
        ((mask & $past(set_bits & DEF_BITS)) == $past(set_bits & DEF_BITS))); // R7
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits != '0) |=> ((mask & $past(clr_bits)) == '0)); // R8
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(mask)); // R9
endmodule

// File: rtl/fic_wmark_reg.sv
module fic_wmark_reg #(
    parameter int W         = 6,
    parameter int RESET_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= W'(RESET_VAL);
        else if (we) q <= wdata;
    end

    AST_WM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R10
    AST_WM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata))); // R10
endmodule

// File: rtl/fic_irq_fsm.sv
module fic_irq_fsm
    import fic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    output logic irq
);
    irq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IRQ_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_QUIET:  if (pend)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!pend) state_nx = IRQ_QUIET;
            default:    state_nx = IRQ_QUIET;
        endcase
    end

    always_comb irq = (state == IRQ_RAISED);

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> irq); // R11
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> !irq); // R11
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fic_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 63,
    parameter int TX_WM_RST  = 1,
    parameter int RX_WM_RST  = 32,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_ovf_pulse,
    input  logic              tx_udf_pulse,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_DISABL = ADDR_W'(OFS_DISABL);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_TXWM   = ADDR_W'(OFS_TXWM);
    localparam logic [ADDR_W-1:0] A_RXWM   = ADDR_W'(OFS_RXWM);

    logic [NBITS-1:0] status, mask, w1c, set_bits, clr_bits;
    logic [LVL_W-1:0] tx_wm, rx_wm;
    logic             we_txwm, we_rxwm, pend;

    always_comb begin
        w1c      = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[NBITS-1:0] : '0;
        set_bits = (reg_wr && reg_addr == A_ENABLE) ? reg_wdata[NBITS-1:0] : '0;
        clr_bits = (reg_wr && reg_addr == A_DISABL) ? reg_wdata[NBITS-1:0] : '0;
        we_txwm  = reg_wr && reg_addr == A_TXWM;
        we_rxwm  = reg_wr && reg_addr == A_RXWM;
        pend     = |(status & mask);
    end

    fic_status_reg #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .tx_wm     (tx_wm),
        .rx_wm     (rx_wm),
        .rx_ovf_ev (rx_ovf_pulse),
        .tx_udf_ev (tx_udf_pulse),
        .clr       (w1c),
        .status    (status)
    );

    fic_mask_reg u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .mask     (mask)
    );

    fic_wmark_reg #(.W(LVL_W), .RESET_VAL(TX_WM_RST)) u_txwm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_txwm),
        .wdata (reg_wdata[LVL_W-1:0]),
        .q     (tx_wm)
    );

    fic_wmark_reg #(.W(LVL_W), .RESET_VAL(RX_WM_RST)) u_rxwm (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_rxwm),
        .wdata (reg_wdata[LVL_W-1:0]),
        .q     (rx_wm)
    );

    fic_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STATUS: reg_rdata = {{(DATA_W-NBITS){1'b0}}, status};
            A_MASK:   reg_rdata = {{(DATA_W-NBITS){1'b0}}, mask};
            A_TXWM:   reg_rdata = {{(DATA_W-LVL_W){1'b0}}, tx_wm};
            A_RXWM:   reg_rdata = {{(DATA_W-LVL_W){1'b0}}, rx_wm};
            default:  reg_rdata = '0;
        endcase
    end

    AST_STATUS_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~DEF_BITS) == '0); // R2
    AST_MASK_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask & ~DEF_BITS) == '0); // R2
endmodule

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  tx_level = '0;
    logic [5:0]  rx_level = '0;
    logic        rx_ovf_pulse = 1'b0;
    logic        tx_udf_pulse = 1'b0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    fifo_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
        .rx_level(rx_level), .rx_ovf_pulse(rx_ovf_pulse),
        .tx_udf_pulse(tx_udf_pulse), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 status after reset", 8'h04, 32'h04);
        rd_chk("R1 mask after reset", 8'h10, 32'h00);
        rd_chk("R1 tx watermark reset", 8'h28, 32'h01);
        rd_chk("R1 rx watermark reset", 8'h2C, 32'h20);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_levels();
        tx_level = 6'd10; step();
        rd_chk("R3 tx above watermark", 8'h04, 32'h00);
        tx_level = 6'd63; step();
        rd_chk("R3 tx full", 8'h04, 32'h08);
        rx_level = 6'd31; step();
        rd_chk("R4 rx below watermark", 8'h04, 32'h08);
        rx_level = 6'd32; step();
        rd_chk("R4 rx at watermark", 8'h04, 32'h18);
        rx_level = 6'd63; step();
        rd_chk("R4 rx full", 8'h04, 32'h38);
        tx_level = 6'd0; rx_level = 6'd0; step();
        rd_chk("R3 tx empty below watermark", 8'h04, 32'h04);
    endtask

    task automatic t_sticky();
        rx_ovf_pulse = 1'b1; step(); rx_ovf_pulse = 1'b0;
        rd_chk("R5 rx overflow set", 8'h04, 32'h05);
        step(); step(); step();
        rd_chk("R5 rx overflow held", 8'h04, 32'h05);
        wr(8'h04, 32'h40);
        rd_chk("R6 clear of other bit keeps overflow", 8'h04, 32'h05);
        wr(8'h04, 32'h01);
        rd_chk("R6 overflow cleared", 8'h04, 32'h04);
        tx_udf_pulse = 1'b1; step(); tx_udf_pulse = 1'b0;
        rd_chk("R5 tx underflow set", 8'h04, 32'h44);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R6 all-ones clear keeps live level bit", 8'h04, 32'h04);
        rx_ovf_pulse = 1'b1;
        wr(8'h04, 32'h01);
        rx_ovf_pulse = 1'b0;
        rd_chk("R6 event wins over same-cycle clear", 8'h04, 32'h05);
        wr(8'h04, 32'h01);
        rd_chk("R6 cleanup clear", 8'h04, 32'h04);
    endtask

    task automatic t_mask();
        wr(8'h08, 32'h15);
        rd_chk("R7 enable sets bits", 8'h10, 32'h15);
        wr(8'h08, 32'h00);
        rd_chk("R7 enable zeros no effect", 8'h10, 32'h15);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R2 enable all sets only defined bits", 8'h10, 32'h7D);
        wr(8'h0C, 32'h05);
        rd_chk("R8 disable clears bits", 8'h10, 32'h78);
        wr(8'h10, 32'h00);
        rd_chk("R9 mask write ignored", 8'h10, 32'h78);
        rd_chk("R7 enable reads zero", 8'h08, 32'h00);
        rd_chk("R8 disable reads zero", 8'h0C, 32'h00);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R8 disable all", 8'h10, 32'h00);
    endtask

    task automatic t_wmark();
        wr(8'h28, 32'h5);
        rd_chk("R10 tx watermark write", 8'h28, 32'h05);
        tx_level = 6'd4; step();
        rd_chk("R3 tx below programmed watermark", 8'h04, 32'h04);
        tx_level = 6'd5; step();
        rd_chk("R3 tx at programmed watermark", 8'h04, 32'h00);
        wr(8'h28, 32'hFFFF_FFFF);
        rd_chk("R10 tx watermark upper bits zero", 8'h28, 32'h3F);
        step();
        rd_chk("R3 tx below max watermark", 8'h04, 32'h04);
        wr(8'h28, 32'h1); tx_level = 6'd0;
        wr(8'h2C, 32'h2); rx_level = 6'd2; step();
        rd_chk("R4 rx at programmed watermark", 8'h04, 32'h14);
        rx_level = 6'd1; step();
        rd_chk("R4 rx below programmed watermark", 8'h04, 32'h04);
        wr(8'h2C, 32'h20); rx_level = 6'd0;
        rd_chk("R10 rx watermark write", 8'h2C, 32'h20);
    endtask

    task automatic t_irq();
        rx_ovf_pulse = 1'b1; step(); rx_ovf_pulse = 1'b0;
        step();
        chk("R11 masked source no irq", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h01);
        chk("R11 irq latency one clock", {31'b0, irq}, 32'h0);
        step();
        chk("R11 irq raised", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h01);
        chk("R11 irq held one clock after clear", {31'b0, irq}, 32'h1);
        step();
        chk("R11 irq dropped", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h04); step();
        chk("R11 irq from level bit", {31'b0, irq}, 32'h1);
        tx_level = 6'd10; step();
        chk("R11 irq still high while status updates", {31'b0, irq}, 32'h1);
        step();
        chk("R11 irq drops after level goes away", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h7F); tx_level = 6'd0; step();
    endtask

    task automatic t_unmapped();
        wr(8'h40, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped reads zero", 8'h40, 32'h00);
        rd_chk("R12 unmapped write leaves mask", 8'h10, 32'h00);
        rd_chk("R12 unmapped write leaves tx watermark", 8'h28, 32'h01);
        rd_chk("R12 unmapped write leaves status", 8'h04, 32'h04);
        wr(8'h08, 32'h02);
        rd_chk("R2 bit1 cannot be enabled", 8'h10, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_levels();
        t_sticky();
        t_mask();
        t_wmark();
        t_irq();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule